// File: doc/BRIEF.md
# Chainable SPI Command Target

This block is an SPI target meant to sit in a chain of identical devices. All devices share chip select and serial clock; the serial output of one device feeds the serial input of the next. Each device holds a 16-bit word in a shift register, so the chain as a whole behaves as one long shift register. A host fills the chain with one command word per device in a single chip-select frame. The word meant for the last device is sent first.

The device executes nothing while bits stream through it. When chip select is released, every device decodes the 16 bits left in its own register at the same moment. The upper three bits are the opcode, the next five bits are the address, and the low byte is the data. A write stores the data byte in the addressed register. A read replaces the word with the register value, which the host collects in a second frame clocked with all-zero NOP words. A frame whose length is not a multiple of 16 bits still executes the last 16 bits each device received.

The serial pins are sampled with the system clock through synchronizers. SCK must therefore run well below the system clock. The serial pins are plain wires, so there is no valid/ready handshake and no back-pressure. The host alone paces the transfer through SCK.

Top module: `daisy_spi_slave`

## Requirements
- R1: The serial output presents the bit that entered on the serial input 16 SCK rising edges earlier. In a 64-bit frame through three devices, the first 16-bit word sent appears as the last 16 bits returned.
- R2: The serial input is captured on SCK rising edges. The serial output changes only after an SCK falling edge or a chip-select falling edge, so it is stable while SCK is high.
- R3: A held word with bits [15:13] = 110 writes bits [7:0] into the register addressed by bits [12:8] when chip select rises.
- R4: Registers change only at a chip-select rising edge. A command word that merely passes through a device during a frame has no effect on it.
- R5: A held word with bits [15:13] = 100 loads the shift register, at chip-select rise, with 0x00 in the upper byte and the addressed register value in the lower byte. The next frame shifts this word out.
- R6: Any opcode other than 110 or 100, including the all-zero NOP word, changes no register and leaves the shift register as it was.
- R7: Addresses at or above NUM_REGS are ignored by writes, read back as 0x00, and do not alias onto implemented registers. The highest implemented address works normally.
- R8: The output enable is high only while chip select is low.
- R9: After reset, all registers and the shift register hold zero and the serial output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low, shared by the chain |
| sck | input | 1 | Serial clock, idle low, shared by the chain |
| sdi | input | 1 | Serial data in, from the host or the previous device |
| sdo | output | 1 | Serial data out, to the next device or the host |
| sdo_en | output | 1 | Output enable for the serial data out pad |

## Verification
The bench chains three instances built with NUM_REGS = 6 and the default two-stage synchronizers. With six registers, both the highest implemented address (5) and absent addresses (6, which shares its low bits with 110, and 31) fall inside the five-bit address field. This makes the range check and the absence of aliasing observable. A 64-bit frame through the three-device chain exposes the 16-bit delay and shows that a word passing through a device is not executed. A second NOP frame after a read-out shows that NOP does not reload the response.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  localparam int OP_W = 3;
  typedef enum logic [OP_W-1:0] {
    OP_NOP   = 3'b000,
    OP_READ  = 3'b100,
    OP_WRITE = 3'b110
  } dsc_op_e;
endpackage

// File: rtl/dsc_sync.sv
module dsc_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] pipe;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe <= {STAGES{RST_VAL}};
      prev <= RST_VAL;
    end else begin
      pipe <= {pipe[STAGES-2:0], din};
      prev <= pipe[STAGES-1];
    end
  end

  assign level = pipe[STAGES-1];
  assign rise  = level & ~prev;
  assign fall  = ~level & prev;
endmodule

// File: rtl/dsc_shifter.sv
module dsc_shifter #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              sdi_bit,
  input  logic              load_en,
  input  logic [WORD_W-1:0] load_word,
  input  logic              out_upd,
  output logic [WORD_W-1:0] shreg,
  output logic              sdo_bit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
    end else if (load_en) begin
      shreg <= load_word;
    end else if (shift_en) begin
      shreg <= {shreg[WORD_W-2:0], sdi_bit};
    end
  end

  // output bit moves only on SCK fall or CS fall (mode 0 launch)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdo_bit <= 1'b0;
    end else if (out_upd) begin
      sdo_bit <= shreg[WORD_W-1];
    end
  end
endmodule

// File: rtl/dsc_regfile.sv
module dsc_regfile
  import dsc_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 5,
  parameter int NUM_REGS = 8,
  localparam int WORD_W  = 2 * DATA_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       exec_en,
  input  logic [WORD_W-1:0]          cmd_word,
  output logic                       load_en,
  output logic [WORD_W-1:0]          load_word,
  output logic [NUM_REGS*DATA_W-1:0] regs_flat
);
  logic [DATA_W-1:0] regs [NUM_REGS];
  logic [OP_W-1:0]   op;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] data;
  logic [DATA_W-1:0] rd_val;

  assign op   = cmd_word[WORD_W-1 -: OP_W];
  assign addr = cmd_word[DATA_W +: ADDR_W];
  assign data = cmd_word[DATA_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
    end else if (exec_en && op == OP_WRITE) begin
      for (int i = 0; i < NUM_REGS; i++)
        if (addr == ADDR_W'(i)) regs[i] <= data;
    end
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (addr == ADDR_W'(i)) rd_val = regs[i];
  end

  assign load_en   = exec_en && (op == OP_READ);
  assign load_word = {{DATA_W{1'b0}}, rd_val};

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
    assign regs_flat[g*DATA_W +: DATA_W] = regs[g];
  end
endmodule

// File: rtl/daisy_spi_slave.sv
module daisy_spi_slave #(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 5,
  parameter int NUM_REGS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic sdi,
  output logic sdo,
  output logic sdo_en
);
  localparam int WORD_W = 2 * DATA_W;

  logic cs_lvl, cs_rise, cs_fall;
  logic sck_lvl, sck_rise, sck_fall;
  logic sdi_s, sdi_r_unused, sdi_f_unused;
  logic shift_en, sdo_upd, load_en, sdo_bit;
  logic [WORD_W-1:0]          shreg, load_word;
  logic [NUM_REGS*DATA_W-1:0] regs_flat;

  dsc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
    .clk(clk), .rst_n(rst_n), .din(cs_n),
    .level(cs_lvl), .rise(cs_rise), .fall(cs_fall));

  dsc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sck_sync (
    .clk(clk), .rst_n(rst_n), .din(sck),
    .level(sck_lvl), .rise(sck_rise), .fall(sck_fall));

  dsc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sdi_sync (
    .clk(clk), .rst_n(rst_n), .din(sdi),
    .level(sdi_s), .rise(sdi_r_unused), .fall(sdi_f_unused));

  assign shift_en = sck_rise & ~cs_lvl;
  assign sdo_upd  = (sck_fall & ~cs_lvl) | cs_fall;

  dsc_shifter #(.WORD_W(WORD_W)) u_shifter (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .sdi_bit(sdi_s),
    .load_en(load_en), .load_word(load_word), .out_upd(sdo_upd),
    .shreg(shreg), .sdo_bit(sdo_bit));

  dsc_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_regfile (
    .clk(clk), .rst_n(rst_n), .exec_en(cs_rise), .cmd_word(shreg),
    .load_en(load_en), .load_word(load_word), .regs_flat(regs_flat));

  assign sdo    = sdo_bit;
  assign sdo_en = ~cs_n;
endmodule

// File: rtl/dsc_checker.sv
module dsc_checker #(
  parameter int WORD_W = 16,
  parameter int REGS_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              shift_en,
  input logic              sdi_s,
  input logic              cs_rise,
  input logic              cs_fall,
  input logic              sck_fall,
  input logic [WORD_W-1:0] shreg,
  input logic              sdo_bit,
  input logic [REGS_W-1:0] regs_flat
);
  a_r1_shift_step: assert property (@(posedge clk) disable iff (!rst_n)
    $past(shift_en) |-> shreg == {$past(shreg[WORD_W-2:0]), $past(sdi_s)});

  a_r2_sdo_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo_bit) |-> $past(sck_fall || cs_fall));

  a_r4_regs_at_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regs_flat) |-> $past(cs_rise));

  a_r5_read_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cs_rise) && $past(shreg[WORD_W-1 -: 3]) == 3'b100)
      |-> shreg[WORD_W-1 -: WORD_W/2] == '0);

  a_r6_other_keeps_word: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cs_rise) && $past(shreg[WORD_W-1 -: 3]) != 3'b100)
      |-> shreg == $past(shreg));
endmodule

bind daisy_spi_slave dsc_checker #(.WORD_W(WORD_W), .REGS_W(NUM_REGS*DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .sdi_s(sdi_s),
  .cs_rise(cs_rise), .cs_fall(cs_fall), .sck_fall(sck_fall),
  .shreg(shreg), .sdo_bit(sdo_bit), .regs_flat(regs_flat));

// File: tb/daisy_spi_slave_bench.sv
`timescale 1ns/1ps
module daisy_spi_slave_bench;
  localparam int NREG = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sck = 1'b0;
  logic host_mosi = 1'b0;
  logic s0, s1, s2, e0, e1, e2;
  int n_chk = 0;
  int n_fail = 0;
  int mode_err = 0;
  bit done = 0;

  always #4 clk = ~clk;

  daisy_spi_slave #(.NUM_REGS(NREG)) u_daisy_spi_slave (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(host_mosi), .sdo(s0), .sdo_en(e0));
  daisy_spi_slave #(.NUM_REGS(NREG)) u_daisy_spi_slave_1 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(s0), .sdo(s1), .sdo_en(e1));
  daisy_spi_slave #(.NUM_REGS(NREG)) u_daisy_spi_slave_2 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(s1), .sdo(s2), .sdo_en(e2));

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic logic [15:0] wr(input logic [4:0] a, input logic [7:0] d);
    return {3'b110, a, d};
  endfunction
  function automatic logic [15:0] rd(input logic [4:0] a);
    return {3'b100, a, 8'h00};
  endfunction

  // mosi is left aligned; miso collects bits in arrival order
  task automatic xfer(input int nbits, input logic [63:0] mosi, output logic [63:0] miso);
    logic pre;
    miso = '0;
    cs_n = 1'b0;
    tick(8);
    for (int i = 0; i < nbits; i++) begin
      host_mosi = mosi[63-i];
      tick(8);
      pre = s2;
      miso = {miso[62:0], pre};
      sck = 1'b1;
      tick(8);
      if (s2 !== pre) mode_err++;
      sck = 1'b0;
    end
    tick(8);
    cs_n = 1'b1;
    tick(12);
  endtask

  task automatic frame3(input logic [15:0] w2, input logic [15:0] w1, input logic [15:0] w0,
                        output logic [47:0] got);
    logic [63:0] m;
    xfer(48, {w2, w1, w0, 16'h0}, m);
    got = m[47:0];
  endtask

  task automatic read3(input logic [4:0] a2, input logic [4:0] a1, input logic [4:0] a0,
                       output logic [47:0] got);
    logic [47:0] dummy;
    frame3(rd(a2), rd(a1), rd(a0), dummy);
    frame3(16'h0, 16'h0, 16'h0, got);
  endtask

  task automatic t_reset;
    logic [47:0] g;
    chk("R8 sdo_en idle", {61'h0, e2, e1, e0}, 64'h0);
    chk("R9 sdo after reset", {63'h0, s2}, 64'h0);
    read3(5'd0, 5'd5, 5'd3, g);
    chk("R9 regs zero after reset", {16'h0, g}, 64'h0);
  endtask

  task automatic t_sdo_en;
    cs_n = 1'b0;
    tick(2);
    chk("R8 sdo_en selected", {61'h0, e2, e1, e0}, 64'h7);
    cs_n = 1'b1;
    tick(2);
    chk("R8 sdo_en deselected", {61'h0, e2, e1, e0}, 64'h0);
    tick(12);
  endtask

  task automatic t_write_read;
    logic [47:0] g;
    frame3(wr(5'd0, 8'h7E), wr(5'd3, 8'hCF), wr(5'd1, 8'h1F), g);
    read3(5'd0, 5'd3, 5'd1, g);
    chk("R3 R5 write then read", {16'h0, g}, {16'h0, 16'h007E, 16'h00CF, 16'h001F});
  endtask

  task automatic t_nop_no_reload;
    logic [47:0] g;
    frame3(16'h0, 16'h0, 16'h0, g);
    chk("R6 NOP leaves shifted zeros", {16'h0, g}, 64'h0);
  endtask

  task automatic t_top_addr;
    logic [47:0] g;
    frame3(wr(5'd5, 8'h11), wr(5'd5, 8'h22), wr(5'd5, 8'h33), g);
    read3(5'd5, 5'd5, 5'd5, g);
    chk("R7 highest address", {16'h0, g}, {16'h0, 16'h0011, 16'h0022, 16'h0033});
  endtask

  task automatic t_out_of_range;
    logic [47:0] g;
    frame3(wr(5'd6, 8'hAA), wr(5'd31, 8'hBB), wr(5'd6, 8'hCC), g);
    read3(5'd6, 5'd31, 5'd6, g);
    chk("R7 absent address reads zero", {16'h0, g}, 64'h0);
    read3(5'd5, 5'd5, 5'd5, g);
    chk("R7 no aliasing", {16'h0, g}, {16'h0, 16'h0011, 16'h0022, 16'h0033});
    read3(5'd0, 5'd0, 5'd0, g);
    chk("R7 addr0 untouched", {16'h0, g}, {16'h0, 16'h007E, 16'h0000, 16'h0000});
  endtask

  task automatic t_other_ops;
    logic [47:0] g;
    frame3({3'b111, 5'd0, 8'hFF}, {3'b010, 5'd3, 8'hFF}, {3'b101, 5'd1, 8'hFF}, g);
    frame3(16'h0, 16'h0, 16'h0, g);
    // R6: unknown words stay in place and come back unchanged
    chk("R6 unknown op keeps word", {16'h0, g},
        {16'h0, 3'b111, 5'd0, 8'hFF, 3'b010, 5'd3, 8'hFF, 3'b101, 5'd1, 8'hFF});
    read3(5'd0, 5'd3, 5'd1, g);
    chk("R6 unknown op no write", {16'h0, g}, {16'h0, 16'h007E, 16'h00CF, 16'h001F});
  endtask

  task automatic t_passthrough;
    logic [63:0] m;
    logic [47:0] g;
    xfer(64, {wr(5'd2, 8'h3C), 16'h0, 16'h0, 16'h0}, m);
    chk("R1 16-bit delay per device", m, {48'h0, wr(5'd2, 8'h3C)});
    read3(5'd2, 5'd2, 5'd2, g);
    chk("R4 passed word not executed", {16'h0, g}, 64'h0);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(5);
    t_reset();
    t_sdo_en();
    t_write_read();
    t_nop_no_reload();
    t_top_addr();
    t_out_of_range();
    t_other_ops();
    t_passthrough();
    chk("R2 sdo stable while sck high", 64'(mode_err), 64'h0);
    if (!done) begin
      done = 1;
      summary();
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired got=running exp=finished");
      summary();
      $finish;
    end
  end
endmodule